// File: doc/BRIEF.md
# Shadowed Serial Register Port with Update Strobe

This block is a serial programming port for a bank of byte-wide control registers. A host frames each access with an active-low select and clocks bits in on the rising edge of a serial clock. Writes never reach the control outputs directly. They land in a shadow buffer, and a single update event later copies every shadow byte into the active bank in the same clock cycle. Several settings can therefore change together.

The update event comes from one of two sources. In internal mode, which is the default, a 32-bit period counter running on the system clock fires the copy. The update pin is then an output, and it carries an 8-cycle high pulse for each copy. In external mode the pin is an input, and its rising edge starts the copy. Both the mode and the period are held in the active bank itself. A mode change therefore takes effect only on the next update.

All serial inputs are oversampled in the system clock domain. The host's serial clock must be several system clocks per half period. Read data comes either on the shared bidirectional data line (2-wire) or on a dedicated output (3-wire).

Top module: `rp_regport`

## Requirements
- R1: A transaction is 16 serial bits sent MSB first while `cs_n` is low. Each bit is sampled on a rising edge of `sclk`. The first byte is the instruction: bit 7 is the direction (1 = read, 0 = write), bit 6 is ignored, and bits 5:0 are the address. The second byte is the data. A write changes only the shadow byte at that address.
- R2: Writes to addresses at or above `NREG` have no effect on any register. Serial bits beyond the sixteenth in one select window are ignored.
- R3: A read returns the active register at the address. The byte is sent MSB first. Its MSB is valid after the eighth rising `sclk` edge, and each following bit advances after a falling edge. In 2-wire mode (control register 0, bit 1 = 0) the data appears on `sdio_o`, and `sdio_oe` is high during the data phase. `sdo` stays 0 in 2-wire mode.
- R4: In 3-wire mode (register 0, bit 1 = 1) read data appears on `sdo`, and `sdio_oe` stays low.
- R5: In internal mode (register 0, bit 0 = 0) the period P is the little-endian value of registers 1 to 4, with a default of 64. When P is nonzero, a copy happens every P system clocks. `upd_o` rises in the cycle the active bank changes, stays high for 8 cycles, and `upd_oe` is 1. When P is 0, no copy ever happens.
- R6: In external mode (register 0, bit 0 = 1) `upd_oe` is 0. A rising edge on `upd_i` copies the bank, and the new values are visible after the third rising clock edge, counting the first edge that samples `upd_i` high. A level held high and a falling edge cause no copy.
- R7: Pulsing `io_rst` abandons a partly shifted transaction, and the next bits start a new instruction. Shadow and active contents are kept.
- R8: Master reset `rst` (active high, synchronous) loads every shadow and active register with its default: 64 in register 1, 0 everywhere else. This gives internal mode with 2-wire reads, `upd_oe` = 1 and `sdio_oe` = 0.
- R9: The active bank changes only on a copy, and a copy transfers all shadow bytes at once.
- R10: Raising `cs_n` before the sixteenth bit discards the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| io_rst | input | 1 | Serial protocol recovery reset, active high |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Transaction select, active low |
| sdio_i | input | 1 | Serial data in (input side of bidirectional line) |
| sdio_o | output | 1 | Serial read data for the bidirectional line |
| sdio_oe | output | 1 | Drive enable for the bidirectional line |
| sdo | output | 1 | Read data in 3-wire mode |
| upd_i | input | 1 | Update pin, input side |
| upd_o | output | 1 | Update pin, output side (copy pulse) |
| upd_oe | output | 1 | Update pin drive enable (1 in internal mode) |
| act_flat | output | NREG*8 | Active register bank, register n at bits 8n+7:8n |

## Verification
The properties assume that the update pin is driven only while `upd_oe` is low. They also assume that the period is normally left larger than the 8-cycle pulse, so that pulses stay apart. The stimulus switches into external mode before it toggles `upd_i`, uses periods of 64 and 20, and uses 0 only to stop the internal strobe. Serial half periods are 6 system clocks, so every `sclk` edge and data bit passes the two-stage synchroniser before the next edge. The read-data bit is also stable when the bench samples it.

// File: rtl/rp_pkg.sv
package rp_pkg;
  // Field positions decoded by the update and serial logic
  localparam int CTRL_ADDR  = 0;
  localparam int CTRL_EXT   = 0;  // 1: update pin is an input
  localparam int CTRL_3W    = 1;  // 1: read data on dedicated output
  localparam int PER_ADDR   = 1;  // period, little endian, from here upward
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rp_serial.sv
module rp_serial #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_rst_s,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          sdi_s,
  input  logic          three_wire,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          sdo
);
  localparam int FRAME = 2*DW;
  localparam int CW = $clog2(FRAME+1);

  logic          sclk_d;
  logic          rise, fall;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] instr, dsh, obyte;
  logic          ld_q, rd_act;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || io_rst_s || csn_s) begin
      bcnt    <= '0;
      instr   <= '0;
      dsh     <= '0;
      obyte   <= '0;
      ld_q    <= 1'b0;
      rd_act  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      ld_q  <= 1'b0;
      if (rise && bcnt < CW'(FRAME)) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt < CW'(DW)) begin
          instr <= {instr[DW-2:0], sdi_s};
        end else begin
          dsh <= {dsh[DW-2:0], sdi_s};
          if (bcnt == CW'(FRAME-1) && !instr[DW-1]) begin
            wr_en   <= 1'b1;
            wr_addr <= instr[AW-1:0];
            wr_data <= {dsh[DW-2:0], sdi_s};
          end
        end
        if (bcnt == CW'(DW-1)) ld_q <= 1'b1;
      end
      if (ld_q) begin
        rd_act <= instr[DW-1];
        obyte  <= rd_data;
      end else if (fall && rd_act && bcnt > CW'(DW)) begin
        obyte <= {obyte[DW-2:0], 1'b0};
      end
    end
  end

  assign rd_addr = instr[AW-1:0];
  assign sdio_o  = obyte[DW-1];
  assign sdio_oe = rd_act & ~three_wire;
  assign sdo     = rd_act & three_wire & obyte[DW-1];
endmodule

// File: rtl/rp_update.sv
module rp_update #(
  parameter int PERW = 32,
  parameter int PULSE_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_mode,
  input  logic [PERW-1:0] period,
  input  logic            upd_i,
  output logic            xfer,
  output logic            upd_o,
  output logic            upd_oe
);
  localparam int PCW = $clog2(PULSE_W+1);

  logic            u1, u2, xtick, itick;
  logic [PERW-1:0] cnt;
  logic [PCW-1:0]  pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      u1     <= 1'b0;
      u2     <= 1'b0;
      xtick  <= 1'b0;
      itick  <= 1'b0;
      cnt    <= '0;
      pcnt   <= '0;
      upd_o  <= 1'b0;
      upd_oe <= 1'b1;
    end else begin
      u1     <= upd_i;
      u2     <= u1;
      xtick  <= ext_mode & u1 & ~u2;
      upd_oe <= ~ext_mode;
      if (ext_mode || period == '0) begin
        cnt   <= '0;
        itick <= 1'b0;
      end else if (cnt >= period - 1'b1) begin
        cnt   <= '0;
        itick <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        itick <= 1'b0;
      end
      if (itick && !ext_mode) begin
        upd_o <= 1'b1;
        pcnt  <= PCW'(PULSE_W-1);
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end else begin
        upd_o <= 1'b0;
      end
    end
  end

  assign xfer = ext_mode ? xtick : itick;
endmodule

// File: rtl/rp_regport.sv
module rp_regport #(
  parameter int NREG = 16,
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int PERW = 32,
  parameter int PULSE_W = 8,
  parameter int DEF_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo,
  input  logic             upd_i,
  output logic             upd_o,
  output logic             upd_oe,
  output logic [NREG*DW-1:0] act_flat
);
  import rp_pkg::*;

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PER_BYTES = PERW / DW;

  logic [DW-1:0]  buf_q [NREG];
  logic [DW-1:0]  act_q [NREG];
  logic           io_rst_s, csn_s, sclk_s, sdi_s;
  logic           wr_en, xfer, ext_mode, three_wire;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [DW-1:0]  wr_data, rd_data;
  logic [PERW-1:0] period;

  rp_sync #(.W(4), .STAGES(SYNC_DEPTH), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({io_rst, cs_n, sclk, sdio_i}),
    .q   ({io_rst_s, csn_s, sclk_s, sdi_s})
  );

  rp_serial #(.AW(AW), .DW(DW)) u_serial (
    .clk        (clk),
    .rst        (rst),
    .io_rst_s   (io_rst_s),
    .sclk_s     (sclk_s),
    .csn_s      (csn_s),
    .sdi_s      (sdi_s),
    .three_wire (three_wire),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sdio_o     (sdio_o),
    .sdio_oe    (sdio_oe),
    .sdo        (sdo)
  );

  rp_update #(.PERW(PERW), .PULSE_W(PULSE_W)) u_update (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (ext_mode),
    .period   (period),
    .upd_i    (upd_i),
    .xfer     (xfer),
    .upd_o    (upd_o),
    .upd_oe   (upd_oe)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] DV =
      (g >= PER_ADDR && g < PER_ADDR + PER_BYTES) ?
      DW'(DEF_PERIOD >> (DW * (g - PER_ADDR))) : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        buf_q[g] <= DV;
        act_q[g] <= DV;
      end else begin
        if (wr_en && wr_addr == AW'(g)) buf_q[g] <= wr_data;
        if (xfer) act_q[g] <= buf_q[g];
      end
    end
    assign act_flat[g*DW +: DW] = act_q[g];
  end

  for (genvar b = 0; b < PER_BYTES; b++) begin : g_per
    assign period[b*DW +: DW] = act_q[PER_ADDR + b];
  end

  assign ext_mode   = act_q[CTRL_ADDR][CTRL_EXT];
  assign three_wire = act_q[CTRL_ADDR][CTRL_3W];
  assign rd_data    = (int'(rd_addr) < NREG) ? act_q[rd_addr[IW-1:0]] : '0;
endmodule

// File: rtl/rp_regport_chk.sv
module rp_regport_chk #(
  parameter int AFW = 128
) (
  input logic           clk,
  input logic           rst,
  input logic           xfer,
  input logic           upd_o,
  input logic           upd_oe,
  input logic           ext_mode,
  input logic           three_wire,
  input logic           sdio_oe,
  input logic           sdo,
  input logic [AFW-1:0] act_flat
);
  // R5: output pulse starts right after a copy cycle
  a_r5_pulse_on_copy: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_o) |-> $past(xfer));

  // R9: bank is frozen unless a copy happened
  a_r9_bank_frozen: assert property (@(posedge clk) disable iff (rst)
    (!$past(xfer) && !$past(rst)) |-> $stable(act_flat));

  // R6: pin not driven in external mode
  a_r6_pin_released: assert property (@(posedge clk) disable iff (rst)
    ($past(ext_mode) && ext_mode && !$past(rst)) |-> !upd_oe);

  // R4: shared line never driven in 3-wire mode
  a_r4_no_shared_drive: assert property (@(posedge clk) disable iff (rst)
    three_wire |-> !sdio_oe);

  // R3: dedicated output quiet in 2-wire mode
  a_r3_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
    !three_wire |-> !sdo);
endmodule

bind rp_regport rp_regport_chk #(.AFW(NREG*DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer       (xfer),
  .upd_o      (upd_o),
  .upd_oe     (upd_oe),
  .ext_mode   (ext_mode),
  .three_wire (three_wire),
  .sdio_oe    (sdio_oe),
  .sdo        (sdo),
  .act_flat   (act_flat)
);

// File: tb/rp_regport_bench.sv
module rp_regport_bench;
  localparam int NREG = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_rst = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0, upd_i = 1'b0;
  logic sdio_o, sdio_oe, sdo, upd_o, upd_oe;
  logic [NREG*8-1:0] act_flat;

  int checks = 0;
  int fails = 0;
  logic [7:0] bufm [NREG];
  logic [7:0] actm [NREG];

  always #5 clk = ~clk;

  rp_regport u_rp_regport (
    .clk(clk), .rst(rst), .io_rst(io_rst), .sclk(sclk), .cs_n(cs_n),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo),
    .upd_i(upd_i), .upd_o(upd_o), .upd_oe(upd_oe), .act_flat(act_flat)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = actm[i];
    return f;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      bufm[i] = (i == 1) ? 8'd64 : 8'd0;
      actm[i] = bufm[i];
    end
  endtask

  task automatic model_copy();
    for (int i = 0; i < NREG; i++) actm[i] = bufm[i];
  endtask

  // shift n bits (MSB first from bit n-1), capture last 8 samples
  task automatic spi_raw(input logic [31:0] bits, input int n,
                         output logic [7:0] r2, output logic [7:0] r3, output logic oe_any);
    r2 = '0; r3 = '0; oe_any = 1'b0;
    for (int i = n-1; i >= 0; i--) begin
      sdio_i = bits[i];
      wclk(HALF);
      if (i < 8) begin
        r2[i] = sdio_oe ? sdio_o : 1'b0;
        r3[i] = sdo;
        oe_any = oe_any | sdio_oe;
      end
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_word(input logic [15:0] w, output logic [7:0] r2,
                          output logic [7:0] r3, output logic oe_any);
    cs_n = 1'b0;
    wclk(HALF);
    spi_raw({16'h0, w}, 16, r2, r3, oe_any);
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2*HALF);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r2, r3; logic oe;
    spi_word({2'b00, a, d}, r2, r3, oe);
    if (int'(a) < NREG) bufm[a] = d;
  endtask

  task automatic wait_rise(output int waited);
    logic prev;
    prev = upd_o;
    waited = 0;
    while (!(upd_o && !prev) && waited < 2000) begin
      prev = upd_o;
      wclk(1);
      waited++;
    end
  endtask

  task automatic ext_pulse();
    upd_i = 1'b1; wclk(4);
    upd_i = 1'b0; wclk(4);
    model_copy();
  endtask

  task automatic t_reset();
    check("R8 reset bank", act_flat, model_flat());
    check("R8 reset upd_oe", 128'(upd_oe), 128'(1));
    check("R8 reset sdio_oe", 128'(sdio_oe), 128'(0));
  endtask

  task automatic t_internal();
    int w, hi;
    wr(5, 8'hA5);
    wr(6, 8'h3C);
    wait_rise(w);
    model_copy();
    check("R5 copy at pulse", act_flat, model_flat());
    hi = 0;
    while (upd_o && hi < 50) begin wclk(1); hi++; end
    check("R5 pulse width", 128'(hi), 128'(8));
    wait_rise(w);
    check("R5 default spacing", 128'(w + hi), 128'(64));
    wr(1, 8'd20);
    wait_rise(w);
    model_copy();
    wait_rise(w);
    wait_rise(w);
    check("R5 period 20 spacing", 128'(w), 128'(20));
    check("R5 upd_oe internal", 128'(upd_oe), 128'(1));
  endtask

  task automatic t_read2();
    logic [7:0] r2, r3; logic oe;
    spi_word({2'b10, 6'd1, 8'h00}, r2, r3, oe);
    check("R3 2-wire read", 128'(r2), 128'(20));
    check("R3 sdio_oe during read", 128'(oe), 128'(1));
    check("R3 sdo quiet", 128'(r3), 128'(0));
  endtask

  task automatic t_3wire();
    logic [7:0] r2, r3; logic oe; int w;
    wr(0, 8'h02);
    wait_rise(w);
    model_copy();
    spi_word({2'b10, 6'd5, 8'h00}, r2, r3, oe);
    check("R4 3-wire read", 128'(r3), 128'(8'hA5));
    check("R4 no shared drive", 128'(oe), 128'(0));
  endtask

  task automatic t_external();
    int w;
    wr(0, 8'h01);
    wait_rise(w);
    model_copy();
    wclk(3);
    check("R6 upd_oe low", 128'(upd_oe), 128'(0));
    wr(7, 8'h5A);
    wclk(100);
    check("R9 no copy without event", act_flat, model_flat());
    upd_i = 1'b1;
    wclk(2);
    check("R6 old after two edges", act_flat, model_flat());
    wclk(1);
    model_copy();
    check("R6 new after third edge", act_flat, model_flat());
    wr(7, 8'h11);
    wclk(50);
    check("R6 held high no copy", act_flat, model_flat());
    upd_i = 1'b0;
    wclk(20);
    check("R6 falling no copy", act_flat, model_flat());
    ext_pulse();
    check("R6 second rising copies", act_flat, model_flat());
  endtask

  task automatic t_oob();
    logic [7:0] r2, r3; logic oe;
    wr(6'h30, 8'hFF);
    spi_word({2'b01, 6'd3, 8'h66}, r2, r3, oe);
    bufm[3] = 8'h66;
    cs_n = 1'b0; wclk(HALF);
    spi_raw({8'h0, 2'b00, 6'd2, 8'h77, 8'hEE}, 24, r2, r3, oe);
    wclk(HALF); cs_n = 1'b1; wclk(2*HALF);
    bufm[2] = 8'h77;
    ext_pulse();
    check("R2 out-of-range and extra bits ignored", act_flat, model_flat());
    check("R1 reserved bit ignored", 128'(act_flat[3*8 +: 8]), 128'(8'h66));
  endtask

  task automatic t_abort();
    logic [7:0] r2, r3; logic oe;
    cs_n = 1'b0; wclk(HALF);
    spi_raw({16'h0, 2'b00, 6'd8, 8'h99} >> 6, 10, r2, r3, oe);
    wclk(HALF); cs_n = 1'b1; wclk(2*HALF);
    ext_pulse();
    check("R10 partial discarded", act_flat, model_flat());
    cs_n = 1'b0; wclk(HALF);
    spi_raw({16'h0, 2'b00, 6'd9, 8'hAB} >> 4, 12, r2, r3, oe);
    io_rst = 1'b1; wclk(4); io_rst = 1'b0; wclk(4);
    spi_raw({16'h0, 2'b00, 6'd10, 8'hCD}, 16, r2, r3, oe);
    wclk(HALF); cs_n = 1'b1; wclk(2*HALF);
    bufm[10] = 8'hCD;
    ext_pulse();
    check("R7 recovery keeps contents", act_flat, model_flat());
  endtask

  task automatic t_pzero();
    int seen;
    wr(1, 8'h00);
    wr(0, 8'h00);
    ext_pulse();
    wclk(4);
    check("R5 back to internal", 128'(upd_oe), 128'(1));
    wr(11, 8'h42);
    seen = 0;
    for (int i = 0; i < 300; i++) begin wclk(1); if (upd_o) seen++; end
    check("R5 period zero no pulse", 128'(seen), 128'(0));
    check("R5 period zero no copy", act_flat, model_flat());
  endtask

  task automatic t_mreset();
    rst = 1'b1; wclk(3); rst = 1'b0; wclk(2);
    model_reset();
    check("R8 master reset bank", act_flat, model_flat());
    check("R8 master reset upd_oe", 128'(upd_oe), 128'(1));
  endtask

  initial begin
    model_reset();
    wclk(5);
    rst = 1'b0;
    wclk(2);
    t_reset();
    t_internal();
    t_read2();
    t_3wire();
    t_external();
    t_oob();
    t_abort();
    t_pzero();
    t_mreset();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule